// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a byte mailbox between a host bus and an embedded controller CPU, organised like a PC keyboard controller. The host writes bytes into an inbound register. The CPU writes bytes into an outbound register. A status byte tells each side whether a byte is waiting and whether the last host byte was a command or data.

Each buffer-full flag is set by the producer's write. It is cleared as a side effect of the consumer's read. Both sides are plain single-cycle strobes with no back-pressure. A write is always accepted and overwrites any unread byte, and a read is always answered in the same cycle.

Each side has a level interrupt that follows the flag it cares about while that interrupt is enabled. The CPU may write the user-defined status bits. The host sees the status byte as read-only.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status byte is 00h and both interrupts are low. Data registers are not reset.
- R2: A host write (`host_wr`) stores `host_wdata` in the inbound register for either value of `host_a2`. In the next cycle `cpu_in_data` shows the byte and status bit 1 (inbound full) is 1.
- R3: On every host write, status bit 3 (command/data) takes the value of `host_a2`, where 1 means command and 0 means data.
- R4: A CPU read strobe (`cpu_rd_in`) without a simultaneous host write clears status bit 1 in the next cycle.
- R5: A CPU output write (`cpu_wr_out`) stores `cpu_wdata` in the outbound register and sets status bit 0 (outbound full) in the next cycle.
- R6: A host read with `host_a2`=0 returns the outbound byte on `host_rdata` in the same cycle. Without a simultaneous CPU output write, it clears status bit 0 in the next cycle.
- R7: A host read with `host_a2`=1 returns the status byte and leaves the status byte unchanged.
- R8: A CPU status write (`cpu_wr_stat`) loads bits 7..4 and bit 2 from `cpu_wdata`. Bits 3, 1 and 0 are not changed by it.
- R9: `cpu_irq` equals status bit 1 AND `cpu_irq_en`. `host_irq` equals status bit 0 AND `host_irq_en`.
- R10: When a set and a clear of the same full flag fall in one cycle, the set wins. The flag stays 1 and the new byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_a2 | input | 1 | Host address bit: 0 selects data, 1 selects status (read) or command (write) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_irq | output | 1 | Host-side interrupt level |
| host_irq_en | input | 1 | Host interrupt enable |
| cpu_rd_in | input | 1 | CPU read strobe for the inbound register |
| cpu_wr_out | input | 1 | CPU write strobe for the outbound register |
| cpu_wr_stat | input | 1 | CPU write strobe for the user-defined status bits |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_in_data | output | 8 | Inbound register contents |
| cpu_status | output | 8 | Status byte as seen by the CPU |
| cpu_irq | output | 1 | CPU-side interrupt level |
| cpu_irq_en | input | 1 | CPU interrupt enable |

## Verification
Every byte value is written by the host at both address-bit settings. This tells a dropped or swapped data bit apart from a wrong command/data flag, and a status peek in between shows whether reading status disturbs anything.

Every byte is also sent outbound and read back by the host, with the full flag and the interrupt watched on both edges. A sweep of all 256 status-write values, with the hardware flags held at 1, separates the writable bits from the protected ones. Same-cycle set and clear collisions on each flag, and all four enable combinations, show the set-wins priority and the interrupt gating.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int DW         = 8;
  localparam int BIT_OBF    = 0;
  localparam int BIT_IBF    = 1;
  localparam int BIT_CD     = 3;
  localparam logic [DW-1:0] UD_MASK = 8'hF4;
endpackage

// File: rtl/kbc_flag.sv
module kbc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port
  import kbc_pkg::*;
(
  input  logic          host_rd,
  input  logic          host_a2,
  input  logic [DW-1:0] out_q,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] rdata,
  output logic          data_rd
);
  always_comb begin
    rdata   = host_a2 ? status : out_q;
    data_rd = host_rd && !host_a2;
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_a2,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  input  logic          host_irq_en,
  input  logic          cpu_rd_in,
  input  logic          cpu_wr_out,
  input  logic          cpu_wr_stat,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_in_data,
  output logic [DW-1:0] cpu_status,
  output logic          cpu_irq,
  input  logic          cpu_irq_en
);
  logic [DW-1:0] in_q, out_q, ud_q, status;
  logic          cd_q, ibf, obf, host_data_rd;

  // data registers carry no reset
  always_ff @(posedge clk) begin
    if (host_wr)    in_q  <= host_wdata;
    if (cpu_wr_out) out_q <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cd_q <= 1'b0;
      ud_q <= '0;
    end else begin
      if (host_wr)     cd_q <= host_a2;
      if (cpu_wr_stat) ud_q <= cpu_wdata & UD_MASK;
    end
  end

  kbc_flag u_ibf (.clk(clk), .rst_n(rst_n), .set_i(host_wr),
                  .clr_i(cpu_rd_in), .q_o(ibf));
  kbc_flag u_obf (.clk(clk), .rst_n(rst_n), .set_i(cpu_wr_out),
                  .clr_i(host_data_rd), .q_o(obf));

  always_comb begin
    status          = ud_q & UD_MASK;
    status[BIT_OBF] = obf;
    status[BIT_IBF] = ibf;
    status[BIT_CD]  = cd_q;
  end

  kbc_host_port u_host (.host_rd(host_rd), .host_a2(host_a2), .out_q(out_q),
                        .status(status), .rdata(host_rdata), .data_rd(host_data_rd));

  assign cpu_in_data = in_q;
  assign cpu_status  = status;
  assign cpu_irq     = ibf & cpu_irq_en;
  assign host_irq    = obf & host_irq_en;

  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> cpu_status[BIT_IBF]);
  p_cd_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> cpu_status[BIT_CD] == $past(host_a2));
  p_obf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_out |=> cpu_status[BIT_OBF]);
  p_obf_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_a2 && !cpu_wr_out) |=> !cpu_status[BIT_OBF]);
  p_stat_peek_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_a2 && !host_wr && !cpu_wr_out && !cpu_rd_in && !cpu_wr_stat)
      |=> $stable(cpu_status));
  p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_stat && !host_wr && !cpu_wr_out && !cpu_rd_in && !host_rd)
      |=> (cpu_status & ~UD_MASK) == ($past(cpu_status) & ~UD_MASK));
  always_comb begin
    p_irq_gate_r9: assert (!(cpu_irq && !cpu_irq_en) && !(host_irq && !host_irq_en));
  end
endmodule

// File: tb/test_kbc_mailbox.sv
module test_kbc_mailbox;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, host_a2 = 0, host_irq_en = 0;
  logic cpu_rd_in = 0, cpu_wr_out = 0, cpu_wr_stat = 0, cpu_irq_en = 0;
  logic [7:0] host_wdata = 0, cpu_wdata = 0;
  logic [7:0] host_rdata, cpu_in_data, cpu_status;
  logic host_irq, cpu_irq;
  int n_run = 0, n_fail = 0;
  logic [7:0] e_ud = 0;
  logic e_cd = 0, e_ibf = 0, e_obf = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  kbc_mailbox i_kbc_mailbox (.*);

  function automatic logic [7:0] e_stat();
    return (e_ud & 8'hF4) | {4'b0, e_cd, 1'b0, e_ibf, e_obf};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_irq(string req);
    chk(req, {6'b0, host_irq, cpu_irq},
        {6'b0, e_obf & host_irq_en, e_ibf & cpu_irq_en});
  endtask

  task automatic hwrite(logic a2, logic [7:0] d);
    @(negedge clk); host_wr = 1; host_a2 = a2; host_wdata = d;
    @(negedge clk); host_wr = 0;
    e_ibf = 1; e_cd = a2;
  endtask

  task automatic hread(logic a2);
    @(negedge clk); host_rd = 1; host_a2 = a2; #1 got = host_rdata;
    @(negedge clk); host_rd = 0;
    if (!a2) e_obf = 0;
  endtask

  task automatic cread();
    @(negedge clk); cpu_rd_in = 1;
    @(negedge clk); cpu_rd_in = 0;
    e_ibf = 0;
  endtask

  task automatic cwrite(logic [7:0] d);
    @(negedge clk); cpu_wr_out = 1; cpu_wdata = d;
    @(negedge clk); cpu_wr_out = 0;
    e_obf = 1;
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", cpu_status, 8'h00);
    chk("R1 irq", {6'b0, host_irq, cpu_irq}, 8'h00);

    cpu_irq_en = 1; host_irq_en = 1;
    // R2 R3 R7 R4 sweep over every byte and both address settings
    for (int d = 0; d < 256; d++) begin
      for (int a = 0; a < 2; a++) begin
        hwrite(a[0], d[7:0]);
        chk("R2 inbound byte", cpu_in_data, d[7:0]);
        chk("R2 R3 status", cpu_status, e_stat());
        chk_irq("R9 cpu irq on");
        hread(1'b1);
        chk("R7 peek value", got, e_stat());
        chk("R7 peek no effect", cpu_status, e_stat());
        cread();
        chk("R4 ibf clear", cpu_status, e_stat());
        chk_irq("R4 R9 irq drop");
      end
    end

    // R5 R6 outbound sweep
    for (int d = 0; d < 256; d++) begin
      cwrite(d[7:0]);
      chk("R5 status", cpu_status, e_stat());
      chk_irq("R5 R9 host irq");
      hread(1'b0);
      chk("R6 read byte", got, d[7:0]);
      chk("R6 obf clear", cpu_status, e_stat());
      chk_irq("R6 host irq drop");
    end

    // R8 with all hardware flags at 1
    hwrite(1'b1, 8'h5A);
    cwrite(8'hA5);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); cpu_wr_stat = 1; cpu_wdata = v[7:0];
      @(negedge clk); cpu_wr_stat = 0;
      e_ud = v[7:0];
      chk("R8 status write", cpu_status, e_stat());
    end

    // R9 all enable combinations with both flags set
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); cpu_irq_en = m[0]; host_irq_en = m[1];
      #1 chk_irq("R9 enable combo");
    end
    cpu_irq_en = 1; host_irq_en = 1;

    // R10 host write collides with CPU read
    @(negedge clk); host_wr = 1; host_a2 = 0; host_wdata = 8'h3C; cpu_rd_in = 1;
    @(negedge clk); host_wr = 0; cpu_rd_in = 0;
    e_ibf = 1; e_cd = 0;
    chk("R10 ibf kept", cpu_status, e_stat());
    chk("R10 new inbound byte", cpu_in_data, 8'h3C);

    // R10 CPU write collides with host data read
    @(negedge clk); cpu_wr_out = 1; cpu_wdata = 8'hC3; host_rd = 1; host_a2 = 0;
    #1 got = host_rdata;
    @(negedge clk); cpu_wr_out = 0; host_rd = 0;
    e_obf = 1;
    chk("R10 old byte read", got, 8'hA5);
    chk("R10 obf kept", cpu_status, e_stat());
    hread(1'b0);
    chk("R10 new outbound byte", got, 8'hC3);
    chk_irq("R10 irq after drain");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule